// File: doc/BRIEF.md
# Reflected CRC-32 Folding Accumulator

This block absorbs a message presented as 128-bit beats and keeps a 128-bit folded remainder for a bit-reflected CRC-32 (least-significant bit first). It does not shift bits through a serial register and does not look up tables. Each new beat costs one cycle. The running remainder is split into two 64-bit halves, and each half is multiplied carry-less by a fold constant. The two 128-bit products are XORed with the byte-reversed incoming beat to form the next remainder.

A message begins with a one-cycle `start` pulse. This pulse captures the initial CRC value and the polynomial choice: CRC-32 for 802.3 with generator 0x04C11DB7 (reflected 0xEDB88320), or CRC-32C with generator 0x1EDC6F41 (reflected 0x82F63B78). The beat flagged `in_last` closes the message. One cycle later, `done` pulses and `rem_out` holds the folded remainder, ready for a separate 32-bit reduction stage.

Top module: `crc32r_fold_acc`

## Requirements
- R1: `in_ready` is 1 in every cycle outside reset.
- R2: While `rst` is high at a clock edge, `rem_out` becomes all zeros and `done` becomes 0.
- R3: Every accepted beat is byte-reversed before use: byte lane k (bits 8k+7..8k of `in_data`) moves to lane 15-k.
- R4: The first beat accepted after `start` is not folded. It sets `rem_out` to rev(beat) XOR the 128-bit value that has the captured initial CRC in bits 31..0 and zeros in all other bits.
- R5: Every later accepted beat of the message sets `rem_out` to clmul(rem[127:64], KL) XOR clmul(rem[63:0], KR) XOR rev(beat). Here clmul is the 64x64 carry-less product, 128 bits wide.
- R6: When `poly_sel`=0 (CRC-32), KL=0x0CCAA009E and KR=0x1751997D0. When `poly_sel`=1 (CRC-32C), KL=0x14CD00BD6 and KR=0x0F20C0DFE.
- R7: `done` is high for exactly one cycle, in the cycle that follows acceptance of the beat flagged `in_last`. After that the block takes no more beats until the next `start`.
- R8: A beat offered in the same cycle as `start`, or while no message is open (after reset or after the last beat), is dropped. It leaves `rem_out` unchanged and raises no `done`.
- R9: `rem_out` changes only in the cycle after an accepted beat. In particular, it holds its value from `done` until the first beat of the next message.
- R10: `poly_sel` and `init_crc` are sampled only in the `start` cycle. Changing them during a message has no effect.
- R11: Cycles with `in_valid` low inside a message are idle. The fold sequence resumes unchanged with the next valid beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a message; captures `init_crc` and `poly_sel` |
| init_crc | input | 32 | Initial CRC value, usually all ones |
| poly_sel | input | 1 | 0 = CRC-32 (802.3), 1 = CRC-32C |
| in_valid | input | 1 | A beat is offered |
| in_ready | output | 1 | Always high outside reset |
| in_data | input | 128 | Beat data, byte lane k at bits 8k+7..8k |
| in_last | input | 1 | Marks the final beat of the message |
| rem_out | output | 128 | Registered folded remainder |
| done | output | 1 | One-cycle pulse after the last beat is absorbed |

## Verification
The bound checker watches control behaviour on every cycle. It checks that ready stays high, that reset clears the outputs, that `done` is a single-cycle pulse that only follows a last beat, and that the remainder holds whenever no beat was offered or a `start` was pending. The arithmetic cannot be expressed as a property. This covers the byte reversal, the XOR of the initial value, the carry-less folds with the right constant pair, the capture of settings at `start`, and the handling of bubbles and dropped beats. Only the bench's scenarios show it, by comparing each final remainder with a model built from the requirements.

// File: rtl/crcf_pkg.sv
package crcf_pkg;

  typedef enum logic {
    POLY_IEEE       = 1'b0,
    POLY_CASTAGNOLI = 1'b1
  } poly_e;

  typedef struct packed {
    logic [63:0] k_left;
    logic [63:0] k_right;
  } fold_k_t;

  // Fold-by-128 constants for the reflected domain (each at most 33 bits).
  function automatic fold_k_t fold_consts(input poly_e sel);
    fold_k_t k;
    if (sel == POLY_CASTAGNOLI) begin
      k.k_left  = 64'h0000_0001_4CD0_0BD6;
      k.k_right = 64'h0000_0000_F20C_0DFE;
    end else begin
      k.k_left  = 64'h0000_0000_CCAA_009E;
      k.k_right = 64'h0000_0001_7519_97D0;
    end
    return k;
  endfunction

endpackage

// File: rtl/crcf_byte_rev.sv
module crcf_byte_rev #(
  parameter int LANES = 16
) (
  input  logic [LANES*8-1:0] din,
  output logic [LANES*8-1:0] dout
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign dout[8*(LANES-1-k) +: 8] = din[8*k +: 8];
  end
endmodule

// File: rtl/crcf_clmul.sv
module crcf_clmul #(
  parameter int W = 64
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  logic [2*W-1:0] a_ext;
  assign a_ext = {{W{1'b0}}, a};

  always_comb begin
    p = '0;
    for (int i = 0; i < W; i++) begin
      if (b[i]) p = p ^ (a_ext << i);
    end
  end
endmodule

// File: rtl/crcf_fold_dp.sv
module crcf_fold_dp #(
  parameter int BEAT_W = 128,
  parameter int CRC_W  = 32
) (
  input  logic [BEAT_W-1:0]   rem,
  input  logic [BEAT_W-1:0]   beat,
  input  logic [CRC_W-1:0]    seed,
  input  logic                first,
  input  logic [BEAT_W/2-1:0] k_left,
  input  logic [BEAT_W/2-1:0] k_right,
  output logic [BEAT_W-1:0]   rem_next
);
  localparam int HALF_W = BEAT_W / 2;
  localparam int LANES  = BEAT_W / 8;

  logic [BEAT_W-1:0] beat_rev;
  logic [BEAT_W-1:0] prod_left;
  logic [BEAT_W-1:0] prod_right;
  logic [BEAT_W-1:0] seed_vec;

  crcf_byte_rev #(.LANES(LANES)) u_rev (
    .din  (beat),
    .dout (beat_rev)
  );

  crcf_clmul #(.W(HALF_W)) u_mul_left (
    .a (rem[BEAT_W-1:HALF_W]),
    .b (k_left),
    .p (prod_left)
  );

  crcf_clmul #(.W(HALF_W)) u_mul_right (
    .a (rem[HALF_W-1:0]),
    .b (k_right),
    .p (prod_right)
  );

  assign seed_vec = {{(BEAT_W-CRC_W){1'b0}}, seed};

  always_comb begin
    if (first) rem_next = beat_rev ^ seed_vec;
    else       rem_next = prod_left ^ prod_right ^ beat_rev;
  end
endmodule

// File: rtl/crcf_seq.sv
module crcf_seq (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic in_valid,
  input  logic in_last,
  output logic accept,
  output logic first_beat
);
  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_FOLD} seq_e;
  seq_e state;

  always_comb begin
    accept     = in_valid && !start && (state != S_IDLE);
    first_beat = (state == S_FIRST);
  end

  always_ff @(posedge clk) begin
    if (rst)         state <= S_IDLE;
    else if (start)  state <= S_FIRST;
    else if (accept) state <= in_last ? S_IDLE : S_FOLD;
  end
endmodule

// File: rtl/crc32r_fold_acc.sv
module crc32r_fold_acc #(
  parameter int BEAT_W = 128,
  parameter int CRC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CRC_W-1:0]  init_crc,
  input  logic              poly_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              in_last,
  output logic [BEAT_W-1:0] rem_out,
  output logic              done
);
  import crcf_pkg::*;

  localparam int HALF_W = BEAT_W / 2;

  logic              accept;
  logic              first_beat;
  poly_e             sel_q;
  logic [CRC_W-1:0]  crc_q;
  logic [BEAT_W-1:0] rem_q;
  logic [BEAT_W-1:0] rem_next;
  logic              done_q;
  fold_k_t           kpair;

  assign in_ready = 1'b1;
  assign kpair    = fold_consts(sel_q);

  crcf_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .accept     (accept),
    .first_beat (first_beat)
  );

  crcf_fold_dp #(.BEAT_W(BEAT_W), .CRC_W(CRC_W)) u_dp (
    .rem      (rem_q),
    .beat     (in_data),
    .seed     (crc_q),
    .first    (first_beat),
    .k_left   (kpair.k_left[HALF_W-1:0]),
    .k_right  (kpair.k_right[HALF_W-1:0]),
    .rem_next (rem_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      done_q <= 1'b0;
      sel_q  <= POLY_IEEE;
      crc_q  <= '0;
    end else begin
      done_q <= accept && in_last;
      if (start) begin
        sel_q <= poly_e'(poly_sel);
        crc_q <= init_crc;
      end
      if (accept) rem_q <= rem_next;
    end
  end

  assign rem_out = rem_q;
  assign done    = done_q;
endmodule

// File: rtl/crc32r_fold_chk.sv
module crc32r_fold_chk #(
  parameter int BEAT_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_ready,
  input logic [BEAT_W-1:0] rem_out,
  input logic              done
);
  p_ready_high_r1: assert property (@(posedge clk) disable iff (rst) in_ready);

  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> (rem_out == '0 && !done));

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_valid && in_last && !start));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_start_no_done_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && $stable(rem_out)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(rem_out));
endmodule

bind crc32r_fold_acc crc32r_fold_chk #(.BEAT_W(BEAT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .in_valid (in_valid),
  .in_last  (in_last),
  .in_ready (in_ready),
  .rem_out  (rem_out),
  .done     (done)
);

// File: tb/tb_crc32r_fold_acc.sv
`timescale 1ns/1ps
module tb_crc32r_fold_acc;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [31:0]  init_crc = '0;
  logic         poly_sel = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         in_last = 1'b0;
  logic [127:0] rem_out;
  logic         done;

  int n_checks = 0;
  int n_fail   = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] last_exp = '0;
  bit           mon_on = 1'b0;

  always #4 clk = ~clk;

  crc32r_fold_acc dut (
    .clk(clk), .rst(rst), .start(start), .init_crc(init_crc),
    .poly_sel(poly_sel), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .rem_out(rem_out), .done(done)
  );

  function automatic logic [127:0] m_rev(input logic [127:0] d);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*(15-k) +: 8] = d[8*k +: 8];
    return r;
  endfunction

  function automatic logic [127:0] m_clmul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p = '0;
    for (int i = 0; i < 64; i++) if (b[i]) p = p ^ ({64'b0, a} << i);
    return p;
  endfunction

  function automatic logic [127:0] m_beat(input int seed, input int i);
    logic [31:0] x;
    x = 32'(seed) * 32'h9E37_79B9 + 32'(i) * 32'h85EB_CA6B + 32'h1234_5677;
    return {x ^ 32'hA5A5_0F0F, ~x, {x[15:0], x[31:16]}, x + 32'h0102_0304};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Driver: runs one message and pushes the expected final remainder.
  task automatic send_msg(input logic sel, input logic [31:0] crc, input int nbeats,
                          input int seed, input bit gaps, input bit junk_on_start,
                          input string tag);
    logic [63:0]  kl, kr;
    logic [127:0] rem;
    kl = sel ? 64'h1_4CD0_0BD6 : 64'h0_CCAA_009E;
    kr = sel ? 64'h0_F20C_0DFE : 64'h1_7519_97D0;
    @(negedge clk);
    start = 1'b1; poly_sel = sel; init_crc = crc;
    in_valid = junk_on_start; in_data = ~m_beat(seed, 99); in_last = junk_on_start;
    for (int i = 0; i < nbeats; i++) begin
      @(negedge clk);
      start = 1'b0;
      poly_sel = ~sel;            // R10: ignored after start
      init_crc = ~crc;
      if (gaps && i > 0) begin    // R11: bubble
        in_valid = 1'b0; in_data = m_beat(seed, 77); in_last = 1'b1;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = m_beat(seed, i);
      in_last  = (i == nbeats - 1);
      if (i == 0) rem = m_rev(in_data) ^ {96'b0, crc};
      else rem = m_clmul(rem[127:64], kl) ^ m_clmul(rem[63:0], kr) ^ m_rev(in_data);
    end
    exp_q.push_back(rem);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // Monitor: compares each completed remainder with the queue head.
  initial begin
    bit prev_done = 1'b0;
    forever begin
      @(posedge clk); #2;
      if (mon_on) begin
        if (done) begin
          check(!prev_done, "R7 done wider than one cycle", {127'b0, prev_done}, '0);
          check(in_ready, "R1 ready low", {127'b0, in_ready}, 128'd1);
          if (exp_q.size() == 0) begin
            check(1'b0, "R7/R8 unexpected done", rem_out, last_exp);
          end else begin
            logic [127:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_exp = e;
            check(rem_out === e, t, rem_out, e);
          end
        end
        prev_done = done;
      end
    end
  end

  initial begin
    #1_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [127:0] hold;
    repeat (3) @(posedge clk);
    #2;
    check(rem_out == '0, "R2 reset remainder", rem_out, '0);
    check(!done, "R2 reset done", {127'b0, done}, '0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    check(in_ready, "R1 ready after reset", {127'b0, in_ready}, 128'd1);
    mon_on = 1'b1;

    send_msg(1'b0, 32'h0000_0000, 1, 1, 0, 0, "R3 byte reversal (zero seed)");
    send_msg(1'b0, 32'hFFFF_FFFF, 1, 2, 0, 0, "R4 first beat seed xor");
    send_msg(1'b0, 32'hFFFF_FFFF, 2, 3, 0, 0, "R5 single fold crc32");
    send_msg(1'b0, 32'hDEAD_BEEF, 5, 4, 0, 0, "R6 crc32 constants multi-fold");
    send_msg(1'b1, 32'hFFFF_FFFF, 4, 5, 0, 0, "R6 crc32c constants");
    send_msg(1'b1, 32'h1357_9BDF, 3, 6, 1, 0, "R11 bubbles inside message");
    send_msg(1'b0, 32'h0F0F_F0F0, 3, 7, 0, 1, "R8 beat dropped on start cycle");
    send_msg(1'b1, 32'h8000_0001, 6, 8, 1, 1, "R10 settings captured at start");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all messages completed", 128'(exp_q.size()), '0);

    // R8/R9: beats with no open message are dropped.
    hold = rem_out;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_last = 1'b1; in_data = m_beat(40, i);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (2) @(negedge clk);
    check(rem_out === hold, "R8 idle beats ignored", rem_out, hold);
    check(rem_out === last_exp, "R9 remainder held after done", rem_out, last_exp);

    // R2: reset in the middle of a message clears the outputs.
    @(negedge clk);
    start = 1'b1; init_crc = 32'hFFFF_FFFF; poly_sel = 1'b0;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b1; in_data = m_beat(50, 0); in_last = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; mon_on = 1'b0; rst = 1'b1;
    @(posedge clk); #2;
    check(rem_out == '0 && !done, "R2 mid-message reset", rem_out, '0);
    @(negedge clk); rst = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule